// File: doc/BRIEF.md
# Selectable PRBS Pattern Generator

This block produces a pseudo-random test bit stream for a T1/J1 transmit path. It emits one bit on each clock where the bit enable is high. Two sequence lengths are available. One is a 15-stage maximal-length sequence (period 2^15-1). The other is a 20-stage maximal-length sequence (period 2^20-1), whose output bits are altered so that no run of zeros grows past fourteen. A separate control complements every pattern bit before it leaves the block.

In framed operation, a frame-bit strobe marks the slot that carries the framing bit. In that slot the block drives zero and its shift registers hold, so the pattern resumes unbroken in the next payload bit. A change of the length select takes effect on the next enabled clock. That clock reloads the all-ones seed and emits a zero.

Top module: `prbs_pattern_gen`

## Requirements
- R1: While reset is low, and after it until the first enabled clock, `pat_out` is 0. After reset the active length is the 15-stage sequence and both registers hold the all-ones seed, so the first fifteen emitted bits (invert low) are 1.
- R2: With `len_sel`=0 (15-stage), the emitted bits e satisfy e[t+15] = e[t] XOR e[t+1] (polynomial x^15+x^14+1), and the register never reaches all zeros.
- R3: With `len_sel`=1 (20-stage), the raw bits r satisfy r[t+20] = r[t] XOR r[t+3] (polynomial x^20+x^17+1). The emitted bit is r[t], forced to 1 whenever r[t+1] through r[t+14] are all 0.
- R4: With invert low, the emitted payload bits never contain more than 14 consecutive zeros. Frame-bit slots are not counted. One full 15-stage period contains a run of exactly 14.
- R5: With `invert`=1, every emitted payload bit is the complement of the pattern bit for that position. Frame-bit slots and reload slots are not complemented.
- R6: On an enabled clock with `framed`=1 and `fbit_strobe`=1, `pat_out` becomes 0 and the sequence does not advance. The next payload bit continues the sequence.
- R7: With `framed`=0, `fbit_strobe` has no effect on the output or the sequence.
- R8: When `bit_en` is low, `pat_out` and the sequence state hold. This holds whatever the other inputs do, including `len_sel`. `pat_out` changes only on the clock edge of an enabled bit.
- R9: On the first enabled clock where `len_sel` differs from the active length, the active length switches and both registers reload the all-ones seed. `pat_out` becomes 0 in that slot. The reload takes priority over a frame-bit slot in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | One output bit per clock where high |
| len_sel | input | 1 | 0 = 15-stage sequence, 1 = 20-stage sequence with zero-run limit |
| invert | input | 1 | Complement payload bits when high |
| framed | input | 1 | 1 = framed stream, 0 = unframed |
| fbit_strobe | input | 1 | Marks the framing-bit slot (used only when framed) |
| pat_out | output | 1 | Registered pattern bit |

## Verification
A length change and a frame-bit slot can fall on the same enabled clock. The bench provokes this by flipping `len_sel` in the very cycle that raises `fbit_strobe` while framed. It judges the outcome against a behavioural model: a single zero in that slot, then the all-ones seed of the new length, with no frame hold carried over. It also mixes random enable gaps with pending length changes and strobes, to show that only enabled clocks act on either.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

   typedef enum logic {
      PRBS_LEN15 = 1'b0,
      PRBS_LEN20 = 1'b1
   } prbs_len_e;

   // Exactly one action (or none) per clock
   typedef struct packed {
      logic reload;
      logic fslot;
      logic step;
   } prbs_slot_t;

endpackage

// File: rtl/prbs_lfsr_core.sv
module prbs_lfsr_core #(
   parameter int W         = 15,
   parameter int TAP       = 14,
   parameter bit GUARD_EN  = 1'b0,
   parameter int GUARD_LEN = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic load,
   output logic bit_o
);

   localparam logic [W-1:0] SEED = '1;

   if (W < 3) begin : g_bad_width
      $error("prbs_lfsr_core: W must be at least 3");
   end
   if (TAP < 1 || TAP >= W) begin : g_bad_tap
      $error("prbs_lfsr_core: TAP must lie in 1..W-1");
   end
   if (GUARD_EN && (GUARD_LEN < 1 || GUARD_LEN > W - 1)) begin : g_bad_guard
      $error("prbs_lfsr_core: GUARD_LEN must lie in 1..W-1");
   end

   logic [W-1:0] sr_q;
   logic         fb;

   assign fb = sr_q[W-1] ^ sr_q[TAP-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sr_q <= SEED;
      else if (load)  sr_q <= SEED;
      else if (step)  sr_q <= {sr_q[W-2:0], fb};
   end

   // Emission order is MSB first; the bits below the MSB are the ones that follow
   if (GUARD_EN) begin : g_guard
      logic ahead_zero;
      assign ahead_zero = (sr_q[W-2 -: GUARD_LEN] == '0);
      assign bit_o      = sr_q[W-1] | ahead_zero;
   end else begin : g_plain
      assign bit_o = sr_q[W-1];
   end

   AST_SR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      sr_q != '0);                                                           // R2
   AST_LOAD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (sr_q == SEED));                                              // R9
   AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(sr_q));                                   // R8

endmodule

// File: rtl/prbs_slot_ctrl.sv
module prbs_slot_ctrl
   import prbs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic       len_sel,
   input  logic       framed,
   input  logic       fbit_strobe,
   output prbs_slot_t slot,
   output prbs_len_e  len_q
);

   logic len_change;

   assign len_change  = (len_sel != logic'(len_q));
   assign slot.reload = bit_en && len_change;
   assign slot.fslot  = bit_en && !len_change && framed && fbit_strobe;
   assign slot.step   = bit_en && !len_change && !(framed && fbit_strobe);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           len_q <= PRBS_LEN15;
      else if (slot.reload) len_q <= prbs_len_e'(len_sel);
   end

   AST_LEN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      slot.reload |=> (logic'(len_q) == $past(len_sel)));                    // R9
   AST_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(len_q));                                           // R8

endmodule

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen
   import prbs_pkg::*;
#(
   parameter int SHORT_W    = 15,
   parameter int SHORT_TAP  = 14,
   parameter int LONG_W     = 20,
   parameter int LONG_TAP   = 17,
   parameter int ZERO_LIMIT = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic len_sel,
   input  logic invert,
   input  logic framed,
   input  logic fbit_strobe,
   output logic pat_out
);

   localparam int ZR_W = $clog2(ZERO_LIMIT + 2);
   localparam logic [ZR_W-1:0] ZR_LIM = ZR_W'(ZERO_LIMIT);
   localparam logic [ZR_W-1:0] ZR_SAT = ZR_W'(ZERO_LIMIT + 1);

   if (ZERO_LIMIT > LONG_W - 1) begin : g_bad_limit
      $error("prbs_pattern_gen: ZERO_LIMIT exceeds look-ahead depth");
   end
   if (SHORT_W >= LONG_W) begin : g_bad_order
      $error("prbs_pattern_gen: SHORT_W must be below LONG_W");
   end

   prbs_slot_t slot;
   prbs_len_e  len_q;
   logic       short_bit, long_bit, sel_bit;
   logic       pat_q;

   prbs_slot_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .len_sel     (len_sel),
      .framed      (framed),
      .fbit_strobe (fbit_strobe),
      .slot        (slot),
      .len_q       (len_q)
   );

   prbs_lfsr_core #(
      .W         (SHORT_W),
      .TAP       (SHORT_TAP),
      .GUARD_EN  (1'b0),
      .GUARD_LEN (ZERO_LIMIT)
   ) u_short (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (slot.step && (len_q == PRBS_LEN15)),
      .load  (slot.reload),
      .bit_o (short_bit)
   );

   prbs_lfsr_core #(
      .W         (LONG_W),
      .TAP       (LONG_TAP),
      .GUARD_EN  (1'b1),
      .GUARD_LEN (ZERO_LIMIT)
   ) u_long (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (slot.step && (len_q == PRBS_LEN20)),
      .load  (slot.reload),
      .bit_o (long_bit)
   );

   assign sel_bit = (len_q == PRBS_LEN20) ? long_bit : short_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pat_q <= 1'b0;
      else if (bit_en) pat_q <= slot.step ? (sel_bit ^ invert) : 1'b0;
   end

   assign pat_out = pat_q;

   // Zero-run monitor over payload bits (checker logic only)
   logic [ZR_W-1:0] zrun_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  zrun_q <= '0;
      else if (slot.step) begin
         if (invert || sel_bit)    zrun_q <= '0;
         else if (zrun_q != ZR_SAT) zrun_q <= zrun_q + 1'b1;
      end
   end

   AST_ZERO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      zrun_q <= ZR_LIM);                                                     // R4
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(pat_out));                                         // R8
   AST_FRAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && framed && fbit_strobe) |=> !pat_out);                       // R6
   AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      slot.reload |=> !pat_out);                                             // R9

endmodule

// File: tb/tb_prbs_pattern_gen.sv
module tb_prbs_pattern_gen;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0, len_sel = 1'b0, invert = 1'b0, framed = 1'b0, fbit_strobe = 1'b0;
   logic pat_out;

   always #10 clk = ~clk;

   prbs_pattern_gen dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .len_sel(len_sel),
      .invert(invert), .framed(framed), .fbit_strobe(fbit_strobe), .pat_out(pat_out)
   );

   int    vectors = 0;
   int    fails   = 0;
   string tag     = "R1";

   // behavioural model
   bit q15[$];
   bit q20[$];
   bit m_len = 1'b0;
   bit m_out = 1'b0;
   int dut_zr = 0;
   int dut_zr_max = 0;

   function automatic void seed_all();
      q15.delete(); q20.delete();
      for (int i = 0; i < 15; i++) q15.push_back(1'b1);
      for (int i = 0; i < 20; i++) q20.push_back(1'b1);
   endfunction

   function automatic void check(string t, logic act, logic exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: pat_out=%b expected %b at %0t", t, act, exp, $time);
      end
   endfunction

   task automatic cyc(bit en, bit len, bit inv, bit frm, bit stb);
      bit payload, b, allz;
      bit_en = en; len_sel = len; invert = inv; framed = frm; fbit_strobe = stb;
      payload = 1'b0;
      @(posedge clk);
      if (en) begin
         if (len != m_len) begin
            m_len = len; seed_all(); m_out = 1'b0;
         end else if (frm && stb) begin
            m_out = 1'b0;
         end else begin
            payload = 1'b1;
            if (!m_len) begin
               b = q15[0];
               q15.push_back(q15[0] ^ q15[1]); void'(q15.pop_front());
            end else begin
               allz = 1'b1;
               for (int k = 1; k <= 14; k++) if (q20[k]) allz = 1'b0;
               b = q20[0] | allz;
               q20.push_back(q20[0] ^ q20[3]); void'(q20.pop_front());
            end
            m_out = b ^ inv;
         end
      end
      @(negedge clk);
      check(tag, pat_out, m_out);
      if (payload) begin
         if (inv || pat_out) dut_zr = 0;
         else dut_zr++;
         if (dut_zr > dut_zr_max) dut_zr_max = dut_zr;
      end
   endtask

   initial begin
      #(200000 * 20 + 1000);
      fails++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      seed_all();
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", pat_out, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", pat_out, 1'b0);

      // R1 seed ones, then R2 full 15-stage period
      tag = "R1";
      for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0, 0);
      tag = "R2";
      dut_zr = 0; dut_zr_max = 0;
      for (int i = 0; i < 32800; i++) cyc(1, 0, 0, 0, 0);
      vectors++;
      if (dut_zr_max != 14) begin
         fails++;
         $display("FAIL R4: longest zero run %0d expected 14", dut_zr_max);
      end

      // R8: enable gaps with other inputs moving
      tag = "R8";
      for (int i = 0; i < 400; i++) begin
         bit en;
         en = ($urandom % 3) == 0;
         cyc(en, en ? 1'b0 : 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      end

      // R5: invert toggling
      tag = "R5";
      for (int i = 0; i < 210; i++) cyc(1, 0, ((i / 7) % 2) == 1, 0, 0);

      // R6: framed, strobe every 24th bit
      tag = "R6";
      for (int i = 0; i < 500; i++) cyc(1, 0, i > 250, 1, (i % 24) == 0);

      // R7: unframed, strobe ignored
      tag = "R7";
      for (int i = 0; i < 300; i++) cyc(1, 0, 0, 0, 1'($urandom));

      // R9: length change coinciding with a frame-bit slot
      tag = "R9";
      cyc(1, 1, 0, 1, 1);
      for (int i = 0; i < 30; i++) cyc(1, 1, 0, 1, (i % 10) == 0);

      // R3: long 20-stage run, R4 zero-run limit
      tag = "R3";
      dut_zr = 0; dut_zr_max = 0;
      for (int i = 0; i < 120000; i++) cyc(1, 1, 0, 0, 0);
      vectors++;
      if (dut_zr_max > 14) begin
         fails++;
         $display("FAIL R4: zero run %0d expected at most 14", dut_zr_max);
      end

      // R9: random mix of everything, length flipping
      tag = "R9";
      for (int i = 0; i < 2000; i++)
         cyc(($urandom % 4) != 0, ($urandom % 50) == 0 ? ~m_len : m_len,
             1'($urandom), 1'($urandom), ($urandom % 8) == 0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule